// File: doc/BRIEF.md
# Secondary CPU Bank Window and Local Address Decoder

This block lets a small 8-bit secondary processor reach a 32 KB slice of a 24-bit main address space. A bank base register of 9 bits supplies the upper address lines of that slice.

Software loads the bank base one bit at a time. Each strobed write pushes the existing base one place toward the low end and places the new bit at the top. After nine writes the whole base comes from the last nine bits written, and the bit written first sits at main address bit 15.

The same block also sorts each local 16-bit address into one of three regions:
- The lowest quarter of the local space selects an 8 KB RAM that is mirrored twice across that quarter.
- The upper half of the local space is sent through the bank window.
- The second quarter selects nothing.

Top module: `bank_window_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the bank base is cleared to zero, even if a write strobe is present. After reset, a window access at local 0x8000 translates to main address 0x000000.
- R2: A write happens when `bank_wr` is high at a rising edge. It shifts the 9-bit bank base one place toward bit 15 and loads `bank_bit` into main address bit 23. The new base shows on `xlat_addr[23:15]` from that edge on.
- R3: When `bank_wr` is low, the bank base holds its value. Whatever is driven on `bank_bit` has no effect.
- R4: Nine consecutive writes replace the whole base. The first of the nine bits ends at main address bit 15 and the last at bit 23.
- R5: `xlat_addr[14:0]` always equals `cpu_addr[14:0]`, combinationally. `xlat_addr[23:15]` always equals the bank base.
- R6: `ram_sel` is high exactly when `cpu_addr[15:14]` is 2'b00. `ram_idx` equals `cpu_addr[12:0]`, so local 0x2000 to 0x3FFF mirror 0x0000 to 0x1FFF.
- R7: `win_sel` is high exactly when `cpu_addr[15]` is 1, which covers local 0x8000 to 0xFFFF.
- R8: For local 0x4000 to 0x7FFF, both `ram_sel` and `win_sel` are low. `ram_sel` and `win_sel` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_wr | input | 1 | Write strobe for the bank base |
| bank_bit | input | 1 | Bit shifted into the top of the bank base |
| cpu_addr | input | 16 | Secondary CPU local address |
| xlat_addr | output | 24 | Translated main-space address |
| ram_sel | output | 1 | Local RAM region selected |
| ram_idx | output | 13 | Index into the 8 KB local RAM |
| win_sel | output | 1 | Bank window region selected |

## Verification
The bank base is the only state in the block. An error in it shows up on `xlat_addr[23:15]` at the very next edge after the faulty write, for example a shift in the wrong direction or a lost bit. It can also show up as a drift while no write is made. Tracking nine writes of an asymmetric pattern places every bit position exactly, so a swapped or stuck bit cannot go unseen. The decode outputs have no state, so a wrong region boundary shows up in the same cycle as the local address that crosses it.

// File: rtl/bank_window_pkg.sv
// Package: shared constants and region type for the bank window block.
// Assumes a 24-bit main space, a 16-bit local space and a 32 KB window.
package bank_window_pkg;
    localparam int MAIN_AW_DEF  = 24;
    localparam int LOCAL_AW_DEF = 16;
    localparam int WIN_AW_DEF   = 15;
    localparam int RAM_AW_DEF   = 13;

    typedef enum logic [1:0] {
        REGION_RAM  = 2'd0,
        REGION_GAP  = 2'd1,
        REGION_WIN  = 2'd2
    } region_e;
endpackage

// File: rtl/bank_base_reg.sv
// Module: serial bank base register.
// Each strobed write shifts the base toward its low end and loads the new
// bit at the top. The reset is synchronous and active-low and has priority
// over a write.
module bank_base_reg #(
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic [BASE_W-1:0] base_q
);
    logic [BASE_W-1:0] base_d;

    // Next value: each bit takes its upper neighbour; the top takes the new bit.
    generate
        for (genvar i = 0; i < BASE_W - 1; i++) begin : g_shift
            assign base_d[i] = wr_en ? base_q[i+1] : base_q[i];
        end
    endgenerate
    assign base_d[BASE_W-1] = wr_en ? wr_bit : base_q[BASE_W-1];

    // Base register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    // R3
    // On a cycle without a write, the stored base keeps its value.
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q));
endmodule

// File: rtl/local_decode.sv
// Module: local address decoder.
// Sorts the local address into the mirrored RAM region, an unused gap,
// or the bank window. Purely combinational.
// Assumes the RAM region spans the lowest quarter of the local space.
module local_decode #(
    parameter int LOCAL_AW = 16,
    parameter int RAM_AW   = 13
) (
    input  logic [LOCAL_AW-1:0] addr,
    output logic                ram_sel,
    output logic [RAM_AW-1:0]   ram_idx,
    output logic                win_sel
);
    import bank_window_pkg::*;

    region_e region;

    // Region classification from the top two local address bits.
    always_comb begin
        if (addr[LOCAL_AW-1])                          region = REGION_WIN;
        else if (addr[LOCAL_AW-2] == 1'b0)             region = REGION_RAM;
        else                                           region = REGION_GAP;
    end

    // Region selects and mirrored RAM index.
    always_comb begin
        ram_sel = (region == REGION_RAM);
        win_sel = (region == REGION_WIN);
        ram_idx = addr[RAM_AW-1:0];
    end
endmodule

// File: rtl/bank_window_top.sv
// Module: bank window top level.
// Joins the serial bank base to the low local address bits to form the
// translated address, and decodes the local regions.
// Assumes WIN_AW < MAIN_AW and WIN_AW < LOCAL_AW.
module bank_window_top #(
    parameter int MAIN_AW  = bank_window_pkg::MAIN_AW_DEF,
    parameter int LOCAL_AW = bank_window_pkg::LOCAL_AW_DEF,
    parameter int WIN_AW   = bank_window_pkg::WIN_AW_DEF,
    parameter int RAM_AW   = bank_window_pkg::RAM_AW_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bank_wr,
    input  logic                bank_bit,
    input  logic [LOCAL_AW-1:0] cpu_addr,
    output logic [MAIN_AW-1:0]  xlat_addr,
    output logic                ram_sel,
    output logic [RAM_AW-1:0]   ram_idx,
    output logic                win_sel
);
    localparam int BASE_W = MAIN_AW - WIN_AW;

    logic [BASE_W-1:0] base_q;

    // Serial base register.
    bank_base_reg #(.BASE_W(BASE_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bank_wr),
        .wr_bit (bank_bit),
        .base_q (base_q)
    );

    // Region decoder.
    local_decode #(.LOCAL_AW(LOCAL_AW), .RAM_AW(RAM_AW)) u_dec (
        .addr    (cpu_addr),
        .ram_sel (ram_sel),
        .ram_idx (ram_idx),
        .win_sel (win_sel)
    );

    // Translated address: the base supplies the upper lines, the local address the offset.
    always_comb begin
        xlat_addr = {base_q, cpu_addr[WIN_AW-1:0]};
    end

    // R2
    // After a write, the top translated bit is the written bit.
    top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> xlat_addr[MAIN_AW-1] == $past(bank_bit));

    // R2
    // After a write, the older base bits appear one place lower.
    shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> xlat_addr[MAIN_AW-2:WIN_AW] == $past(xlat_addr[MAIN_AW-1:WIN_AW+1]));

    // R8
    // The RAM and window selects are never active together.
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, win_sel}));

    // R6
    // A RAM select only comes from the lowest quarter of the local space.
    ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> cpu_addr[LOCAL_AW-1:LOCAL_AW-2] == 2'b00);
endmodule

// File: tb/tb_bank_window_top.sv
// Directed bench for bank_window_top; one task per scenario.
module tb_bank_window_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_wr = 1'b0;
    logic        bank_bit = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [23:0] xlat_addr;
    logic        ram_sel;
    logic [12:0] ram_idx;
    logic        win_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [8:0] exp_base = 9'h000;

    bank_window_top dut (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_bit(bank_bit),
        .cpu_addr(cpu_addr), .xlat_addr(xlat_addr), .ram_sel(ram_sel),
        .ram_idx(ram_idx), .win_sel(win_sel)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_bit(input logic b);
        @(negedge clk);
        bank_wr  = 1'b1;
        bank_bit = b;
        @(negedge clk);
        bank_wr  = 1'b0;
        bank_bit = ~b;
        exp_base = {b, exp_base[8:1]};
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; bank_wr = 1'b1; bank_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; bank_wr = 1'b0;
        exp_base = 9'h000;
        cpu_addr = 16'h8000; #1;
        chk(xlat_addr == 24'h000000, "R1 reset base", xlat_addr, 24'h000000);
    endtask

    task automatic t_single;
        write_bit(1'b1);
        cpu_addr = 16'h8000; #1;
        chk(xlat_addr == 24'h800000, "R2 first write at bit 23", xlat_addr, 24'h800000);
        write_bit(1'b0);
        #1;
        chk(xlat_addr == 24'h400000, "R2 shift toward bit 15", xlat_addr, 24'h400000);
    endtask

    task automatic t_hold;
        @(negedge clk);
        bank_wr = 1'b0;
        for (int i = 0; i < 6; i++) begin
            bank_bit = i[0];
            @(negedge clk);
        end
        cpu_addr = 16'h8000; #1;
        chk(xlat_addr[23:15] == exp_base, "R3 hold without strobe", xlat_addr[23:15], exp_base);
    endtask

    task automatic t_nine;
        logic [8:0] pat = 9'b1_0011_0101;
        for (int i = 0; i < 9; i++) write_bit(pat[i]);
        cpu_addr = 16'h8000; #1;
        chk(xlat_addr[23:15] == pat, "R4 nine writes replace base", xlat_addr[23:15], pat);
        chk(xlat_addr[15] == pat[0], "R4 oldest bit at 15", xlat_addr[15], pat[0]);
        for (int i = 0; i < 9; i++) write_bit(~pat[i]);
        #1;
        chk(xlat_addr[23:15] == ~pat, "R4 inverse pattern", xlat_addr[23:15], ~pat);
    endtask

    task automatic t_offset;
        cpu_addr = 16'hABCD; #1;
        chk(xlat_addr == {exp_base, 15'h2BCD}, "R5 window offset", xlat_addr, {exp_base, 15'h2BCD});
        cpu_addr = 16'h7FFF; #1;
        chk(xlat_addr[14:0] == 15'h7FFF, "R5 low bits follow", xlat_addr[14:0], 15'h7FFF);
    endtask

    task automatic t_decode;
        cpu_addr = 16'h0000; #1;
        chk(ram_sel && !win_sel && ram_idx == 13'h0000, "R6 RAM at 0x0000", {ram_sel, win_sel, ram_idx}, {2'b10, 13'h0000});
        cpu_addr = 16'h2345; #1;
        chk(ram_sel && ram_idx == 13'h0345, "R6 RAM mirror", {ram_sel, ram_idx}, {1'b1, 13'h0345});
        cpu_addr = 16'h3FFF; #1;
        chk(ram_sel && ram_idx == 13'h1FFF, "R6 RAM top", {ram_sel, ram_idx}, {1'b1, 13'h1FFF});
        cpu_addr = 16'h4000; #1;
        chk(!ram_sel && !win_sel, "R8 gap low edge", {ram_sel, win_sel}, 2'b00);
        cpu_addr = 16'h7FFF; #1;
        chk(!ram_sel && !win_sel, "R8 gap high edge", {ram_sel, win_sel}, 2'b00);
        cpu_addr = 16'h8000; #1;
        chk(win_sel && !ram_sel, "R7 window low edge", {ram_sel, win_sel}, 2'b01);
        cpu_addr = 16'hFFFF; #1;
        chk(win_sel && !ram_sel, "R7 window high edge", {ram_sel, win_sel}, 2'b01);
    endtask

    initial begin
        t_reset;
        t_single;
        t_hold;
        t_nine;
        t_offset;
        t_decode;
        t_reset;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule